// File: doc/BRIEF.md
# Three-Wire Divider Configuration Register

This block takes configuration words for a frequency synthesizer over a three-wire serial link: a data line, a serial clock and a load strobe. Each word is 19 bits long and is sent most significant bit first. The last bit sent is a routing flag that decides which of two holding latches the word is written into.

A word with the flag set carries the reference divide value and four mode bits: prescaler modulus select, phase detector polarity, lock/monitor output select and charge-pump current select. A word with the flag clear carries the swallow count and the main counter value. The latched fields drive the divider and phase detector logic.

All three serial lines are synchronised into the system clock domain. Serial clock edges and load edges are found there. A load-inhibit input holds off transfers while the supply is settling. A one-cycle strobe marks each latch update. A sticky flag records any load that followed a bit count other than 19.

Top module: `sercfg_top`

## Requirements
- R1: Each rising edge of the serial clock shifts one data bit into a 19-bit register, most significant bit first. The last bit sent ends up at position 0.
- R2: On a load, position 0 selects the destination. A 1 writes the reference latch and a 0 writes the counter latch. The other latch keeps its value.
- R3: Reference word fields are as follows. Positions 14..1 go to `ref_div_o`, with position 1 as its LSB. Position 15 goes to `pre_small_o`, 16 to `phase_inv_o`, 17 to `mon_sel_o` and 18 to `cp_hi_o`.
- R4: Counter word fields are as follows. Positions 7..1 go to `swallow_o`, with position 1 as its LSB. Positions 18..8 go to `main_div_o`, with position 8 as its LSB.
- R5: A latch changes only on a rising edge of the load line. Serial clock edges that arrive while the load line is high are ignored: they neither shift nor count.
- R6: Each accepted load raises `ref_upd_o` or `cnt_upd_o` for exactly one system clock cycle. Only the strobe of the latch that was written is raised.
- R7: A load that follows a bit count other than 19 still updates the selected latch from the last 19 bits shifted. It also sets `len_err_o`, which stays set until reset. A load after exactly 19 bits leaves the flag unchanged.
- R8: A load edge that arrives while `load_inhibit_i` is high is discarded. No latch changes, no strobe is raised, and the bit count is kept.
- R9: Synchronous active-low reset clears every latch output, both strobes and the error flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_load_i | input | 1 | Load strobe (asynchronous) |
| load_inhibit_i | input | 1 | Discards load edges while high |
| ref_div_o | output | 14 | Reference divide value |
| pre_small_o | output | 1 | Prescaler modulus select |
| phase_inv_o | output | 1 | Phase detector polarity |
| mon_sel_o | output | 1 | Lock/monitor output select |
| cp_hi_o | output | 1 | Charge-pump current select |
| swallow_o | output | 7 | Swallow count |
| main_div_o | output | 11 | Main counter value |
| ref_upd_o | output | 1 | One-cycle reference latch update strobe |
| cnt_upd_o | output | 1 | One-cycle counter latch update strobe |
| len_err_o | output | 1 | Sticky bit-count mismatch flag |

## Verification
The bench walks a table of words. The table includes all-zero and all-one fields and alternating bit patterns. A design with a field offset by one position, or with the routing flag read from the wrong end, shows up as a miscompare. A design that corrupts the latch it did not select also shows up.

Directed cases cover the remaining edge conditions. Serial clocks sent while the load line is high must not shift or count. A design that takes them would set the mismatch flag on the next correct word. A load under inhibit must leave the outputs unchanged and raise no strobe. Frames of 21 and 17 bits must latch the last 19 bits shifted and set the flag. The flag must persist through a later good frame, and only reset may clear it.

// File: rtl/sercfg_pkg.sv
// Shared widths, field positions and latch types for the serial
// configuration register. Assumes the routing flag sits at position 0.
package sercfg_pkg;
    localparam int WORD_BITS = 19;
    localparam int R_BITS    = 14;
    localparam int A_BITS    = 7;
    localparam int N_BITS    = 11;
    localparam int MODE_BITS = 4;
    localparam int CTL_POS   = 0;
    localparam int R_LSB     = CTL_POS + 1;
    localparam int MODE_LSB  = R_LSB + R_BITS;
    localparam int A_LSB     = CTL_POS + 1;
    localparam int N_LSB     = A_LSB + A_BITS;
    localparam int CNT_W     = $clog2(WORD_BITS + 2) + 1;

    typedef struct packed {
        logic cp_hi;
        logic mon_sel;
        logic phase_inv;
        logic pre_small;
    } mode_t;

    typedef struct packed {
        logic [R_BITS-1:0] rdiv;
        mode_t             mode;
    } ref_cfg_t;

    typedef struct packed {
        logic [N_BITS-1:0] ndiv;
        logic [A_BITS-1:0] adiv;
    } cnt_cfg_t;
endpackage

// File: rtl/sercfg_sync.sv
// Multi-flop level synchroniser for a bus of independent asynchronous
// bits. Assumes each bit is quasi-static over several clk periods.
module sercfg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        // Shift the raw bit through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = pipe[STAGES-1];
    end
endmodule

// File: rtl/sercfg_shift.sv
// 19-bit serial shift register with a saturating bit counter.
// Assumes shift_evt and load_evt are never true in the same cycle.
module sercfg_shift
    import sercfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_evt,
    input  logic                 dat,
    input  logic                 load_evt,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 len_ok_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_BITS);

    logic [CNT_W-1:0] bit_cnt;

    // Shift a new bit in at position 0 on each serial clock event.
    always_ff @(posedge clk) begin
        if (!rst_n)         word_o <= '0;
        else if (shift_evt) word_o <= {word_o[WORD_BITS-2:0], dat};
    end

    // Count shifted bits since the last load; saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                              bit_cnt <= '0;
        else if (load_evt)                       bit_cnt <= '0;
        else if (shift_evt && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end

    assign len_ok_o = (bit_cnt == CNT_WORD);

    // R5: a shift and a load never collide
    p_no_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_evt && load_evt));
endmodule

// File: rtl/sercfg_latch.sv
// Two destination latches fed from one shift word, routed by the flag
// at position 0, with update strobes and a sticky length-error flag.
module sercfg_latch
    import sercfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_evt,
    input  logic [WORD_BITS-1:0] word,
    input  logic                 len_ok,
    output ref_cfg_t             ref_cfg_o,
    output cnt_cfg_t             cnt_cfg_o,
    output logic                 ref_upd_o,
    output logic                 cnt_upd_o,
    output logic                 len_err_o
);
    logic     to_ref;
    ref_cfg_t ref_next;
    cnt_cfg_t cnt_next;

    // Decode both field layouts from the shift word.
    always_comb begin
        to_ref             = word[CTL_POS];
        ref_next.rdiv      = word[R_LSB +: R_BITS];
        ref_next.mode      = mode_t'(word[MODE_LSB +: MODE_BITS]);
        cnt_next.adiv      = word[A_LSB +: A_BITS];
        cnt_next.ndiv      = word[N_LSB +: N_BITS];
    end

    // Reference latch and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cfg_o <= '0;
            ref_upd_o <= 1'b0;
        end else begin
            ref_upd_o <= load_evt && to_ref;
            if (load_evt && to_ref) ref_cfg_o <= ref_next;
        end
    end

    // Counter latch and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_cfg_o <= '0;
            cnt_upd_o <= 1'b0;
        end else begin
            cnt_upd_o <= load_evt && !to_ref;
            if (load_evt && !to_ref) cnt_cfg_o <= cnt_next;
        end
    end

    // Sticky flag for loads after a wrong bit count.
    always_ff @(posedge clk) begin
        if (!rst_n)                  len_err_o <= 1'b0;
        else if (load_evt && !len_ok) len_err_o <= 1'b1;
    end

    // R6: never both strobes at once
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_upd_o, cnt_upd_o}));
    // R6: strobes last one cycle
    p_ref_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd_o |=> !ref_upd_o);
    p_cnt_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_upd_o |=> !cnt_upd_o);
    // R5: latches hold without their strobe
    p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd_o |-> $stable(ref_cfg_o));
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_upd_o |-> $stable(cnt_cfg_o));
    // R7: error flag is sticky
    p_sticky_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |=> len_err_o);
endmodule

// File: rtl/sercfg_top.sv
// Three-wire configuration register top. Synchronises the serial lines,
// detects clock and load edges in the clk domain, and drives the
// reference and counter latches. Assumes serial levels last >= 3 clks.
module sercfg_top
    import sercfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_load_i,
    input  logic              load_inhibit_i,
    output logic [R_BITS-1:0] ref_div_o,
    output logic              pre_small_o,
    output logic              phase_inv_o,
    output logic              mon_sel_o,
    output logic              cp_hi_o,
    output logic [A_BITS-1:0] swallow_o,
    output logic [N_BITS-1:0] main_div_o,
    output logic              ref_upd_o,
    output logic              cnt_upd_o,
    output logic              len_err_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0]     sync_lvl;
    logic                 clk_lvl, dat_lvl, load_lvl, inh_lvl;
    logic                 clk_prev, load_prev;
    logic                 clk_rise, load_rise, shift_evt, load_evt;
    logic [WORD_BITS-1:0] word;
    logic                 len_ok;
    ref_cfg_t             ref_cfg;
    cnt_cfg_t             cnt_cfg;

    sercfg_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({load_inhibit_i, ser_load_i, ser_dat_i, ser_clk_i}),
        .sync_o  (sync_lvl)
    );

    assign {inh_lvl, load_lvl, dat_lvl, clk_lvl} = sync_lvl;

    // Remember previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev  <= 1'b0;
            load_prev <= 1'b0;
        end else begin
            clk_prev  <= clk_lvl;
            load_prev <= load_lvl;
        end
    end

    assign clk_rise  = clk_lvl && !clk_prev;
    assign load_rise = load_lvl && !load_prev;
    assign shift_evt = clk_rise && !load_lvl;
    assign load_evt  = load_rise && !inh_lvl;

    sercfg_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_evt (shift_evt),
        .dat       (dat_lvl),
        .load_evt  (load_evt),
        .word_o    (word),
        .len_ok_o  (len_ok)
    );

    sercfg_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_evt  (load_evt),
        .word      (word),
        .len_ok    (len_ok),
        .ref_cfg_o (ref_cfg),
        .cnt_cfg_o (cnt_cfg),
        .ref_upd_o (ref_upd_o),
        .cnt_upd_o (cnt_upd_o),
        .len_err_o (len_err_o)
    );

    assign ref_div_o   = ref_cfg.rdiv;
    assign pre_small_o = ref_cfg.mode.pre_small;
    assign phase_inv_o = ref_cfg.mode.phase_inv;
    assign mon_sel_o   = ref_cfg.mode.mon_sel;
    assign cp_hi_o     = ref_cfg.mode.cp_hi;
    assign swallow_o   = cnt_cfg.adiv;
    assign main_div_o  = cnt_cfg.ndiv;

    // R2: reference strobe only for a word whose flag was 1
    p_route_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd_o |-> $past(word[CTL_POS]));
    // R2: counter strobe only for a word whose flag was 0
    p_route_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_upd_o |-> !$past(word[CTL_POS]));
    // R5: word is frozen while load is high
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_lvl |=> $stable(word));
    // R8: inhibited load raises no strobe
    p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rise && inh_lvl) |=> !(ref_upd_o || cnt_upd_o));
endmodule

// File: tb/tb_sercfg_top.sv
module tb_sercfg_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SER   = 3;
    localparam int WATCHDOG   = 50000;
    localparam int NVEC       = 6;
    // Table words: {cp,mon,pol,pre,R[14:1],1} or {N[11:1],A[7:1],0}
    localparam logic [18:0] VEC [NVEC] = '{
        19'h00007,  // ref R=3, modes 0000
        19'h7FFFF,  // ref R=16383, modes 1111
        19'h00300,  // cnt N=3, A=0
        19'h7FFFE,  // cnt N=2047, A=127
        19'h52AAB,  // ref R=0x1555, modes 1010
        19'h2AAAA   // cnt N=0x2AA, A=0x55
    };

    logic clk = 0, rst_n = 0;
    logic sclk = 0, sdat = 0, sload = 0, sinh = 0;
    logic [13:0] ref_div_o;
    logic        pre_small_o, phase_inv_o, mon_sel_o, cp_hi_o;
    logic [6:0]  swallow_o;
    logic [10:0] main_div_o;
    logic        ref_upd_o, cnt_upd_o, len_err_o;

    int n_chk = 0, n_bad = 0, ref_pulses = 0, cnt_pulses = 0;
    bit done = 0;
    logic [18:0] m_ref = '0, m_cnt = '0, last_word = '0;
    logic        m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sercfg_top dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_load_i(sload), .load_inhibit_i(sinh),
        .ref_div_o(ref_div_o), .pre_small_o(pre_small_o),
        .phase_inv_o(phase_inv_o), .mon_sel_o(mon_sel_o), .cp_hi_o(cp_hi_o),
        .swallow_o(swallow_o), .main_div_o(main_div_o),
        .ref_upd_o(ref_upd_o), .cnt_upd_o(cnt_upd_o), .len_err_o(len_err_o)
    );

    always @(posedge clk) begin
        if (ref_upd_o) ref_pulses++;
        if (cnt_upd_o) cnt_pulses++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = w[i];
            tick(HALF_SER);
            sclk = 1;
            tick(HALF_SER);
            sclk = 0;
        end
        tick(HALF_SER);
    endtask

    task automatic pulse_load();
        ref_pulses = 0;
        cnt_pulses = 0;
        sload = 1;
        tick(4);
        sload = 0;
        tick(8);
    endtask

    // Expected outputs from the field layouts of R3 and R4.
    task automatic check_outputs(input string tag);
        chk({tag, " R3 ref_div"},   32'(ref_div_o),   32'(m_ref[14:1]));
        chk({tag, " R3 pre_small"}, 32'(pre_small_o), 32'(m_ref[15]));
        chk({tag, " R3 phase_inv"}, 32'(phase_inv_o), 32'(m_ref[16]));
        chk({tag, " R3 mon_sel"},   32'(mon_sel_o),   32'(m_ref[17]));
        chk({tag, " R3 cp_hi"},     32'(cp_hi_o),     32'(m_ref[18]));
        chk({tag, " R4 swallow"},   32'(swallow_o),   32'(m_cnt[7:1]));
        chk({tag, " R4 main_div"},  32'(main_div_o),  32'(m_cnt[18:8]));
        chk({tag, " R7 len_err"},   32'(len_err_o),   32'(m_err));
    endtask

    task automatic model_load(input logic [18:0] w, input bit ok);
        if (w[0]) m_ref = w; else m_cnt = w;
        if (!ok) m_err = 1;
    endtask

    task automatic check_strobes(input string tag, input logic [18:0] w);
        chk({tag, " R6 ref strobe cycles"}, ref_pulses, w[0] ? 1 : 0);
        chk({tag, " R6 cnt strobe cycles"}, cnt_pulses, w[0] ? 0 : 1);
    endtask

    initial begin
        tick(5);
        rst_n = 1;
        tick(3);
        // R9: reset state
        check_outputs("R9 reset");
        chk("R9 strobes idle", 32'({ref_upd_o, cnt_upd_o}), 0);

        // R1 R2 R3 R4 R6: table walk
        for (int v = 0; v < NVEC; v++) begin
            send_bits(32'(VEC[v]), 19);
            pulse_load();
            model_load(VEC[v], 1);
            check_outputs($sformatf("R1 R2 vec%0d", v));
            check_strobes($sformatf("vec%0d", v), VEC[v]);
        end

        // R5: serial clocks while load is high are ignored
        send_bits(32'(19'h4C3D5), 19);
        ref_pulses = 0; cnt_pulses = 0;
        sload = 1;
        tick(4);
        for (int k = 0; k < 2; k++) begin
            sdat = ~sdat; tick(HALF_SER); sclk = 1; tick(HALF_SER); sclk = 0;
        end
        tick(HALF_SER);
        sload = 0;
        tick(8);
        model_load(19'h4C3D5, 1);
        check_outputs("R5 clocks under load");
        send_bits(32'(19'h1B3C4), 19);
        pulse_load();
        model_load(19'h1B3C4, 1);
        check_outputs("R5 next frame count intact");
        // R5: no load edge, no change
        tick(20);
        check_outputs("R5 idle hold");

        // R8: inhibited load discarded, count kept
        send_bits(32'(19'h35A5B), 19);
        sinh = 1;
        tick(4);
        pulse_load();
        check_outputs("R8 inhibited");
        chk("R8 no strobe", 32'(ref_pulses + cnt_pulses), 0);
        sinh = 0;
        tick(4);
        pulse_load();
        model_load(19'h35A5B, 1);
        check_outputs("R8 after release");
        check_strobes("R8 release", 19'h35A5B);
        last_word = 19'h35A5B;

        // R7: 21-bit frame latches the last 19 bits and sets the flag
        send_bits(32'h1F0F0E, 21);
        pulse_load();
        model_load(19'h70F0E, 0);
        check_outputs("R7 long frame");
        check_strobes("R7 long", 19'h70F0E);
        last_word = 19'h70F0E;

        // R7: 17-bit frame keeps two old bits on top
        send_bits(32'h0ABCD, 17);
        pulse_load();
        model_load({last_word[1:0], 17'h0ABCD}, 0);
        check_outputs("R7 short frame");

        // R7: flag survives a correct frame
        send_bits(32'(19'h12346), 19);
        pulse_load();
        model_load(19'h12346, 1);
        check_outputs("R7 sticky");

        // R9: reset clears everything again
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(2);
        m_ref = '0; m_cnt = '0; m_err = 0;
        check_outputs("R9 second reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule